// File: doc/BRIEF.md
# Word-Read Receive Byte Queue

This block sits between a serial receive engine and a register read port. The engine hands it one byte at a time over a valid/ready stream. Software drains it by popping 32-bit words. Each pop takes up to four bytes, and the earliest byte appears in the least significant lane. When fewer than four bytes are stored, a pop returns only those bytes and the unused upper lanes read as zero.

A status word reports the state of the queue:
- the current byte count;
- an empty flag and a data-ready flag;
- three nested fill-level flags, which show that at least 16, 32 or 64 bytes are waiting.

Two outputs raise interrupts. A level output signals that data is ready. A sticky flag signals underrun, which means a pop arrived while the queue held nothing. A one-cycle clear strobe empties the queue and drops the underrun flag.

Byte input rules: a byte transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while 64 bytes are stored and during a clear cycle. A pop in the same cycle does not free room for a byte offered in that cycle. The sender keeps `in_byte` steady while it waits.

Top module: `rxq_word_fifo`

## Requirements
- R1: A byte is accepted only when `in_valid` and `in_ready` are both high. `in_ready` is low when 64 bytes are stored or `sw_clear` is high. Accepted bytes come out in the order they arrived.
- R2: A cycle with `rd_pop` high and `sw_clear` low removes min(count, 4) bytes. Before that edge, `rd_word` shows those bytes, with the earliest in bits 7:0 and the next ones in bits 15:8, 23:16 and 31:24.
- R3: When fewer than four bytes are stored, every `rd_word` lane at or above the stored count reads as zero.
- R4: `status[0]` is high exactly when at least one byte is stored. `status[11]` is high exactly when no byte is stored.
- R5: `status[10:4]` holds the number of stored bytes, from 0 to 64.
- R6: `status[1]`, `status[2]` and `status[3]` are high when at least 16, 32 and 64 bytes are stored, respectively.
- R7: A pop while the queue is empty (and `sw_clear` low) leaves the contents unchanged and sets `irq_underrun` from the next cycle. The flag then stays high until a clear or a reset.
- R8: A cycle with `sw_clear` high empties the queue and drops `irq_underrun`. It overrides any pop or byte offered in the same cycle.
- R9: `irq_ready` is high exactly when at least one byte is stored.
- R10: After reset the queue is empty, `status` reads 12'h800, and `irq_underrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The queue can take the offered byte |
| in_byte | input | 8 | Offered byte |
| rd_pop | input | 1 | Pop up to four bytes this cycle |
| rd_word | output | 32 | Head word, valid before the pop edge |
| sw_clear | input | 1 | Empty the queue and clear underrun |
| status | output | 12 | {empty, count[6:0], ge64, ge32, ge16, ready} |
| irq_ready | output | 1 | Data-ready interrupt level |
| irq_underrun | output | 1 | Sticky underrun error flag |

## Verification
The assertions assume that the sender never holds `in_valid` as a way of forcing a byte into a full queue. They also assume that pop, clear and valid are synchronous one-cycle decisions. The bench drives every input after the falling edge and draws them from weighted random choices, so the sender does not depend on `in_ready`. Pops on an empty queue, clears that collide with a push and a pop, and long runs against a full queue are all deliberate. The bench phases steer the stored count through the partial-word range and through every fill threshold. They also reach the full limit and stay there.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   push,
  input  byte_t                  push_byte,
  input  logic [NW-1:0]          pop_n,
  output logic [LANES-1:0][BYTE_W-1:0] head,
  output logic [CW-1:0]          count
);
  byte_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(push) - CW'(pop_n);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_head
    assign head[l] = mem[rd_ptr + AW'(l)];
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH))); // R1
  AST_POP_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count); // R2
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R8
endmodule

// File: rtl/rxq_pack.sv
module rxq_pack
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0][BYTE_W-1:0] head,
  input  logic [CW-1:0]          count,
  input  logic                   pop_req,
  output logic [LANES*BYTE_W-1:0] word,
  output logic [NW-1:0]          pop_n,
  output logic                   underrun_evt
);
  logic [NW-1:0] take;

  assign take = (count >= CW'(LANES)) ? NW'(LANES) : NW'(count);
  assign pop_n = pop_req ? take : '0;
  assign underrun_evt = pop_req && (count == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word[l*BYTE_W +: BYTE_W] = (CW'(l) < count) ? head[l] : '0;
  end

  AST_POP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count != '0) |-> (pop_n != '0)); // R2
  AST_EMPTY_POP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |-> (pop_n == '0)); // R7
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int DEPTH    = 64,
  parameter int THR_BASE = 16,
  parameter int NUM_THR  = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = NUM_THR + CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          underrun_evt,
  input  logic [CW-1:0] count,
  output logic [SW-1:0] status,
  output logic          irq_ready,
  output logic          irq_underrun
);
  logic [NUM_THR-1:0] thr;
  logic               has_data, is_empty, und_q;

  assign has_data = (count != '0);
  assign is_empty = (count == '0);

  for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
    assign thr[k] = (count >= CW'(THR_BASE << k));
    if (k > 0) begin : g_nest
      AST_THR_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        thr[k] |-> thr[k-1]); // R6
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            und_q <= 1'b0;
    else if (clr)          und_q <= 1'b0;
    else if (underrun_evt) und_q <= 1'b1;
  end

  assign status       = {is_empty, count, thr, has_data};
  assign irq_ready    = has_data;
  assign irq_underrun = und_q;

  AST_READY_XOR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({status[0], status[SW-1]}) == 1); // R4
  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (und_q && !clr) |=> und_q); // R7
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_evt && !clr) |=> und_q); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !und_q); // R8
endmodule

// File: rtl/rxq_word_fifo.sv
module rxq_word_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int LANES    = 4,
  parameter int THR_BASE = 16,
  parameter int NUM_THR  = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1),
  localparam int WW = LANES * BYTE_W,
  localparam int SW = NUM_THR + CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_byte,
  input  logic          rd_pop,
  output logic [WW-1:0] rd_word,
  input  logic          sw_clear,
  output logic [SW-1:0] status,
  output logic          irq_ready,
  output logic          irq_underrun
);
  logic [LANES-1:0][BYTE_W-1:0] head_bytes;
  logic [CW-1:0] fifo_cnt;
  logic [NW-1:0] pop_n;
  logic          push_en, pop_req, underrun_evt;

  assign in_ready = !sw_clear && (fifo_cnt < CW'(DEPTH));
  assign push_en  = in_valid && in_ready;
  assign pop_req  = rd_pop && !sw_clear;

  rxq_store #(.DEPTH(DEPTH), .LANES(LANES)) i_store (
    .clk(clk), .rst_n(rst_n), .clr(sw_clear), .push(push_en),
    .push_byte(in_byte), .pop_n(pop_n), .head(head_bytes), .count(fifo_cnt)
  );

  rxq_pack #(.DEPTH(DEPTH), .LANES(LANES)) i_pack (
    .clk(clk), .rst_n(rst_n), .head(head_bytes), .count(fifo_cnt),
    .pop_req(pop_req), .word(rd_word), .pop_n(pop_n),
    .underrun_evt(underrun_evt)
  );

  rxq_flags #(.DEPTH(DEPTH), .THR_BASE(THR_BASE), .NUM_THR(NUM_THR)) i_flags (
    .clk(clk), .rst_n(rst_n), .clr(sw_clear), .underrun_evt(underrun_evt),
    .count(fifo_cnt), .status(status), .irq_ready(irq_ready),
    .irq_underrun(irq_underrun)
  );

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(DEPTH)) |-> !in_ready); // R1
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(1)) |-> (rd_word[WW-1:BYTE_W] == '0)); // R3
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready == status[0]); // R9
endmodule

// File: tb/test_rxq_word_fifo.sv
module test_rxq_word_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, rd_pop = 1'b0, sw_clear = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready, irq_ready, irq_underrun;
  logic [31:0] rd_word;
  logic [11:0] status;

  int   n_vec = 0, n_bad = 0;
  bit   done = 0;
  byte unsigned q[$];
  bit   und_m = 0;
  byte unsigned seq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_word_fifo i_rxq_word_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .rd_pop(rd_pop), .rd_word(rd_word),
    .sw_clear(sw_clear), .status(status), .irq_ready(irq_ready),
    .irq_underrun(irq_underrun)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] w = '0;
    int sz = q.size();
    for (int i = 0; i < 4; i++) if (i < sz) w[8*i +: 8] = q[i];
    chk("R1 in_ready", 32'(in_ready), 32'(!sw_clear && sz < DEPTH));
    chk(sz < 4 ? "R3 partial rd_word" : "R2 rd_word", rd_word, w);
    chk("R4 ready bit", 32'(status[0]), 32'(sz > 0));
    chk("R4 empty bit", 32'(status[11]), 32'(sz == 0));
    chk("R5 count field", 32'(status[10:4]), 32'(sz));
    chk("R6 thresholds", 32'(status[3:1]),
        32'({sz >= 64, sz >= 32, sz >= 16}));
    chk("R9 irq_ready", 32'(irq_ready), 32'(sz > 0));
    chk("R7 irq_underrun", 32'(irq_underrun), 32'(und_m));
  endtask

  task automatic model_step();
    bit room = q.size() < DEPTH;
    if (sw_clear) begin
      q.delete();
      und_m = 0;
    end else begin
      if (rd_pop) begin
        if (q.size() == 0) und_m = 1;
        for (int i = 0; i < 4; i++) if (q.size() > 0) void'(q.pop_front());
      end
      if (in_valid && room) q.push_back(in_byte);
    end
  endtask

  task automatic run(int cycles, int pv, int pp, int pc);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid = ($urandom % 100) < pv;
      rd_pop   = ($urandom % 100) < pp;
      sw_clear = ($urandom % 100) < pc;
      if (in_ready || !in_valid) seq = seq + 8'd1;
      in_byte  = seq;
      #1;
      compare_all();
      model_step();
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset status", 32'(status), 32'h800);
    chk("R10 reset underrun", 32'(irq_underrun), 32'd0);
    chk("R10 reset irq_ready", 32'(irq_ready), 32'd0);
    rst_n = 1'b1;
    run(10, 0, 0, 0);
    run(90, 100, 0, 0);    // R1, R6: fill to full and hold
    run(5, 100, 100, 0);   // R1: push and pop at full limit
    run(25, 0, 100, 0);    // R2, R7: drain past empty
    run(1, 0, 0, 100);     // R8: clear drops underrun
    run(6, 100, 0, 0);
    run(1, 100, 100, 100); // R8: clear overrides push and pop
    run(400, 30, 40, 0);   // R3: partial words
    run(2000, 70, 20, 2);
    run(200, 20, 60, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule